// File: doc/BRIEF.md
# Consumer-Electronics-Control Bus Controller Register Block

This block is the software-facing half of a consumer-electronics-control (CEC) bus controller. A CPU reaches it over a simple 32-bit register bus with a select, a write enable and a byte address. Behind it sits a byte-level engine that handles the line timing, arbitration and free-time counting. The register block holds six registers: control, configuration, transmit data, receive data, interrupt status and interrupt enable. It hands the engine one transmit byte at a time and stores each received byte.

Software starts a message by setting a start command and writing the header byte. The block then asks for each further byte through a byte-request status flag. Software sets an end command together with the final byte, or earlier. The start and end commands clear themselves when the engine reports the outcome of the message. They also clear when the engine asks for a byte that software did not supply in time.

Engine events and the block's own events are gathered into sticky status flags, which software clears by writing ones. A single interrupt line is raised whenever an enabled flag is set.

Top module: `cec_reg_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low and the engine outputs are idle.
- R2: Registers decode only at byte offsets 0x00 (control), 0x04 (configuration), 0x08 (TX data), 0x0C (RX data), 0x10 (status) and 0x14 (interrupt enable). Any other address, including unaligned ones, is ignored on write and reads 0.
- R3: Control bit 0 is the enable and can be read and written. Writing 1 to bit 1 sets the start command and writing 1 to bit 2 sets the end command; writing 0 to either leaves it unchanged. While the enable being written or held is 0, both commands read 0.
- R4: Configuration bits 31 (listen-all), 30:16 (own-address mask, bit 16+n for logical address n), 8:3 (error-handling enables) and 2:0 (free-time select) can be read and written, and drive the engine outputs. Bits 15:9 read 0.
- R5: Status flags are sticky. Writing 1 to a status bit clears it and writing 0 has no effect. An event in the same cycle as its clear leaves the flag set.
- R6: The interrupt-enable register holds bits 12:6 and 2:0, and its other bits read 0. `irq` is high exactly when some status bit and its enable bit are both 1.
- R7: A TX data write loads a byte and raises `eng_tx_valid` until the engine takes it. When the engine takes a byte while the end command is 0, status bit 8 (byte request) is set. When the end command is 1, no request is made.
- R8: TX end (status bit 9), TX error (bit 11), arbitration lost (bit 7) and TX missing acknowledge (bit 12) each set their flag and clear the start and end commands.
- R9: If the engine takes a byte while the start command is 1 and no byte is loaded, status bit 10 (underrun) is set and both commands clear. A take while the start command is 0 is ignored.
- R10: A received byte that arrives with the RX buffer empty is stored for RX data reads and sets status bit 0. An RX end event sets bit 1. An RX missing acknowledge sets bit 6 and empties the buffer.
- R11: A byte that arrives while the previous byte is still unread, and is not being read in that cycle, sets status bit 2 (overrun). The new byte is discarded and the buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, valid while bus_sel is high) |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Engine enable |
| eng_som | output | 1 | Start-of-message command |
| eng_eom | output | 1 | End-of-message command |
| eng_tx_valid | output | 1 | A TX byte is loaded |
| eng_tx_byte | output | BYTE_W | Loaded TX byte |
| eng_own_mask | output | NUM_LA | One-hot own logical addresses |
| eng_listen_all | output | 1 | Listen-all mode |
| eng_err_cfg | output | 6 | Error-handling enables |
| eng_sft | output | 3 | Free-time selector |
| eng_tx_take | input | 1 | Engine takes the loaded byte / needs next byte |
| eng_tx_end | input | 1 | Message sent |
| eng_tx_err | input | 1 | Transmit error |
| eng_tx_nack | input | 1 | Transmit not acknowledged |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_byte | input | BYTE_W | Received byte |
| eng_rx_end | input | 1 | Received message end |
| eng_rx_nack | input | 1 | Received byte not acknowledged |

## Verification
The hardest situations to reach are the collisions. One is a flag event in the very cycle that software clears that flag. Another is a second received byte arriving before the first is read. The bench reaches the first by driving the status write and the engine event on the same clock edge. It reaches the second by strobing two received bytes with no read between them, then strobing a third to show the buffer was emptied. The one-byte message is reached by writing the end command before the start command and checking that the engine's take raises no byte request.

// File: rtl/cec_reg_pkg.sv
package cec_reg_pkg;
   localparam int REG_W   = 32;
   localparam int NUM_REG = 6;
   // register index; byte offset is index*4
   localparam int IX_CTRL = 0;
   localparam int IX_CFG  = 1;
   localparam int IX_TXD  = 2;
   localparam int IX_RXD  = 3;
   localparam int IX_STAT = 4;
   localparam int IX_IEN  = 5;
   // status flag positions
   localparam int NFLAG     = 13;
   localparam int ST_RXBYTE = 0;
   localparam int ST_RXEND  = 1;
   localparam int ST_RXOVR  = 2;
   localparam int ST_RXNACK = 6;
   localparam int ST_ARB    = 7;
   localparam int ST_TXREQ  = 8;
   localparam int ST_TXEND  = 9;
   localparam int ST_TXUDR  = 10;
   localparam int ST_TXERR  = 11;
   localparam int ST_TXNACK = 12;
   localparam logic [NFLAG-1:0] FLAG_MASK = 13'h1FC7;
endpackage

// File: rtl/cec_reg_decode.sv
module cec_reg_decode #(
   parameter int ADDR_W = 5,
   parameter int NREG   = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit
);
   localparam int SPAN = NREG * 4;
   if (ADDR_W < $clog2(SPAN)) begin : g_bad_width
      $error("ADDR_W too small for register span");
   end
   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = (addr == ADDR_W'(i * 4));
   end
endmodule

// File: rtl/cec_irq_status.sv
module cec_irq_status #(
   parameter int               NF   = 13,
   parameter logic [NF-1:0]    MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] evt,
   input  logic          clr_we,
   input  logic          ien_we,
   input  logic [NF-1:0] wdata,
   output logic [NF-1:0] flags,
   output logic [NF-1:0] ien,
   output logic          irq
);
   for (genvar i = 0; i < NF; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[i] <= 1'b0;
               ien[i]   <= 1'b0;
            end else begin
               if (evt[i])                    flags[i] <= 1'b1;
               else if (clr_we && wdata[i])   flags[i] <= 1'b0;
               if (ien_we)                    ien[i]   <= wdata[i];
            end
         end
      end else begin : g_tie
         assign flags[i] = 1'b0;
         assign ien[i]   = 1'b0;
      end
   end

   assign irq = |(flags & ien);

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R5
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((flags & $past(wdata & ~evt & MASK)) == '0)); // R5
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq); // R6
endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [2:0]        ctrl_wdata,
   input  logic              txd_we,
   input  logic [BYTE_W-1:0] txd_wdata,
   input  logic              eng_take,
   input  logic              eng_done,
   output logic              en,
   output logic              som,
   output logic              eom,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              req_evt,
   output logic              udr_evt
);
   logic en_next, take_ok, kill;

   assign en_next = ctrl_we ? ctrl_wdata[0] : en;
   assign take_ok = eng_take && som && tx_valid;
   assign udr_evt = eng_take && som && !tx_valid;
   assign req_evt = take_ok && !eom;
   assign kill    = eng_done || udr_evt || !en_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         som      <= 1'b0;
         eom      <= 1'b0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         en <= en_next;
         if (kill)                           som <= 1'b0;
         else if (ctrl_we && ctrl_wdata[1])  som <= 1'b1;
         if (kill)                           eom <= 1'b0;
         else if (ctrl_we && ctrl_wdata[2])  eom <= 1'b1;
         if (kill)          tx_valid <= 1'b0;
         else if (txd_we)   tx_valid <= 1'b1;
         else if (take_ok)  tx_valid <= 1'b0;
         if (txd_we)        tx_byte  <= txd_wdata;
      end
   end

   AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (!som && !eom)); // R8
   AST_UDR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_take && som && !tx_valid) |=> !som); // R9
   AST_TAKE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_take && som && tx_valid && !txd_we) |=> !tx_valid); // R7
endmodule

// File: rtl/cec_rx_buf.sv
module cec_rx_buf #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rd,
   input  logic              flush,
   output logic [BYTE_W-1:0] rx_data,
   output logic              byte_evt,
   output logic              ovr_evt
);
   logic full, busy;

   assign busy     = full && !rd;
   assign ovr_evt  = rx_valid && busy;
   assign byte_evt = rx_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         rx_data <= '0;
      end else begin
         if (ovr_evt || flush) full <= 1'b0;
         else if (byte_evt)    full <= 1'b1;
         else if (rd)          full <= 1'b0;
         if (byte_evt)         rx_data <= rx_byte;
      end
   end

   AST_OVR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && full && !rd) |=> (rx_data == $past(rx_data) && !full)); // R11
   AST_LOAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !full) |=> (rx_data == $past(rx_byte))); // R10
endmodule

// File: rtl/cec_reg_ctrl.sv
module cec_reg_ctrl
   import cec_reg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int BYTE_W = 8,
   parameter int NUM_LA = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              eng_enable,
   output logic              eng_som,
   output logic              eng_eom,
   output logic              eng_tx_valid,
   output logic [BYTE_W-1:0] eng_tx_byte,
   output logic [NUM_LA-1:0] eng_own_mask,
   output logic              eng_listen_all,
   output logic [5:0]        eng_err_cfg,
   output logic [2:0]        eng_sft,
   input  logic              eng_tx_take,
   input  logic              eng_tx_end,
   input  logic              eng_tx_err,
   input  logic              eng_tx_nack,
   input  logic              eng_arb_lost,
   input  logic              eng_rx_valid,
   input  logic [BYTE_W-1:0] eng_rx_byte,
   input  logic              eng_rx_end,
   input  logic              eng_rx_nack
);
   localparam logic [14:0]      LA_BITS  = 15'((32'd1 << NUM_LA) - 1);
   localparam logic [REG_W-1:0] CFG_KEEP = {1'b1, LA_BITS, 7'd0, 9'h1FF};

   if (NUM_LA < 1 || NUM_LA > 15) begin : g_bad_la
      $error("NUM_LA must be 1..15");
   end
   if (BYTE_W < 1 || BYTE_W > 16) begin : g_bad_byte
      $error("BYTE_W must be 1..16");
   end

   logic [NUM_REG-1:0] hit, wr;
   logic               rd_rx;
   logic [REG_W-1:0]   cfg_q;
   logic [NFLAG-1:0]   evt, flags, ien;
   logic [BYTE_W-1:0]  rx_data;
   logic               req_evt, udr_evt, rxb_evt, ovr_evt, tx_done;

   cec_reg_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REG)) u_dec (
      .addr(bus_addr), .hit(hit));

   assign wr    = (bus_sel && bus_we) ? hit : '0;
   assign rd_rx = bus_sel && !bus_we && hit[IX_RXD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q <= '0;
      else if (wr[IX_CFG]) cfg_q <= bus_wdata & CFG_KEEP;
   end

   assign eng_listen_all = cfg_q[31];
   assign eng_own_mask   = cfg_q[16 +: NUM_LA];
   assign eng_err_cfg    = cfg_q[8:3];
   assign eng_sft        = cfg_q[2:0];

   assign tx_done = eng_tx_end || eng_tx_err || eng_tx_nack || eng_arb_lost;

   cec_tx_seq #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(wr[IX_CTRL]), .ctrl_wdata(bus_wdata[2:0]),
      .txd_we(wr[IX_TXD]), .txd_wdata(bus_wdata[BYTE_W-1:0]),
      .eng_take(eng_tx_take), .eng_done(tx_done),
      .en(eng_enable), .som(eng_som), .eom(eng_eom),
      .tx_valid(eng_tx_valid), .tx_byte(eng_tx_byte),
      .req_evt(req_evt), .udr_evt(udr_evt));

   cec_rx_buf #(.BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(eng_rx_valid), .rx_byte(eng_rx_byte),
      .rd(rd_rx), .flush(eng_rx_nack),
      .rx_data(rx_data), .byte_evt(rxb_evt), .ovr_evt(ovr_evt));

   always_comb begin
      evt            = '0;
      evt[ST_RXBYTE] = rxb_evt;
      evt[ST_RXEND]  = eng_rx_end;
      evt[ST_RXOVR]  = ovr_evt;
      evt[ST_RXNACK] = eng_rx_nack;
      evt[ST_ARB]    = eng_arb_lost;
      evt[ST_TXREQ]  = req_evt;
      evt[ST_TXEND]  = eng_tx_end;
      evt[ST_TXUDR]  = udr_evt;
      evt[ST_TXERR]  = eng_tx_err;
      evt[ST_TXNACK] = eng_tx_nack;
   end

   cec_irq_status #(.NF(NFLAG), .MASK(FLAG_MASK)) u_st (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .clr_we(wr[IX_STAT]), .ien_we(wr[IX_IEN]),
      .wdata(bus_wdata[NFLAG-1:0]),
      .flags(flags), .ien(ien), .irq(irq));

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (hit[IX_CTRL]) bus_rdata = {29'd0, eng_eom, eng_som, eng_enable};
         if (hit[IX_CFG])  bus_rdata = cfg_q;
         if (hit[IX_RXD])  bus_rdata = REG_W'(rx_data);
         if (hit[IX_STAT]) bus_rdata = REG_W'(flags);
         if (hit[IX_IEN])  bus_rdata = REG_W'(ien);
      end
   end

   AST_NO_CMD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && hit[IX_CTRL] && !bus_wdata[0]) |=> (!eng_som && !eng_eom)); // R3
   AST_BAD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && hit == '0) |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/tb_cec_reg_ctrl.sv
module tb_cec_reg_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_we = 0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, eng_enable, eng_som, eng_eom, eng_tx_valid, eng_listen_all;
   logic [7:0]  eng_tx_byte;
   logic [14:0] eng_own_mask;
   logic [5:0]  eng_err_cfg;
   logic [2:0]  eng_sft;
   logic        eng_tx_take = 0, eng_tx_end = 0, eng_tx_err = 0, eng_tx_nack = 0;
   logic        eng_arb_lost = 0, eng_rx_valid = 0, eng_rx_end = 0, eng_rx_nack = 0;
   logic [7:0]  eng_rx_byte = '0;

   int n_run = 0, n_fail = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   cec_reg_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .eng_enable(eng_enable), .eng_som(eng_som), .eng_eom(eng_eom),
      .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
      .eng_own_mask(eng_own_mask), .eng_listen_all(eng_listen_all),
      .eng_err_cfg(eng_err_cfg), .eng_sft(eng_sft),
      .eng_tx_take(eng_tx_take), .eng_tx_end(eng_tx_end), .eng_tx_err(eng_tx_err),
      .eng_tx_nack(eng_tx_nack), .eng_arb_lost(eng_arb_lost),
      .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
      .eng_rx_end(eng_rx_end), .eng_rx_nack(eng_rx_nack));

   // {addr, write data, expected readback}
   localparam logic [71:0] VEC [8] = '{
      {8'h00, 32'hFFFF_FFFF, 32'h0000_0007},   // R3
      {8'h00, 32'h0000_0000, 32'h0000_0000},   // R3
      {8'h04, 32'hFFFF_FFFF, 32'hFFFF_01FF},   // R4
      {8'h04, 32'h1234_5678, 32'h1234_0078},   // R4
      {8'h14, 32'hFFFF_FFFF, 32'h0000_1FC7},   // R6
      {8'h14, 32'h0000_0000, 32'h0000_0000},   // R6
      {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},   // R2
      {8'h06, 32'hFFFF_FFFF, 32'h0000_0000}    // R2
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   // 0 take,1 end,2 err,3 txnack,4 arb,5 rxend,6 rxnack
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: eng_tx_take = 1;  1: eng_tx_end = 1;  2: eng_tx_err = 1;
         3: eng_tx_nack = 1;  4: eng_arb_lost = 1; 5: eng_rx_end = 1;
         default: eng_rx_nack = 1;
      endcase
      @(negedge clk);
      {eng_tx_take, eng_tx_end, eng_tx_err, eng_tx_nack, eng_arb_lost, eng_rx_end, eng_rx_nack} = '0;
   endtask

   task automatic rx_byte(input logic [7:0] b);
      @(negedge clk);
      eng_rx_valid = 1; eng_rx_byte = b;
      @(negedge clk);
      eng_rx_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      for (int i = 0; i < 6; i++) begin
         rd(5'(i * 4), rv);
         chk("R1 reg after reset", rv, 0);
      end
      chk("R1 irq/tx idle", {30'd0, irq, eng_tx_valid}, 0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         wr(VEC[i][68:64], VEC[i][63:32]);
         rd(VEC[i][68:64], rv);
         chk($sformatf("R2/R3/R4/R6 vector %0d", i), rv, VEC[i][31:0]);
      end
      rd(5'h04, rv);
      chk("R2 config untouched by bad address", rv, 32'h1234_0078);
      chk("R4 engine config outputs", {eng_listen_all, 1'b0, eng_own_mask, 4'd0, eng_err_cfg, eng_sft},
          {1'b0, 1'b0, 15'h1234, 4'd0, 6'h0F, 3'd0});

      // R5/R6 sticky, W1C, irq
      wr(5'h00, 32'h1);
      pulse(5);
      rd(5'h10, rv);  chk("R10 rx end flag", rv, 32'h2);
      chk("R6 irq masked", {31'd0, irq}, 0);
      wr(5'h14, 32'h2);
      chk("R6 irq raised", {31'd0, irq}, 1);
      wr(5'h10, 32'h0);
      rd(5'h10, rv);  chk("R5 write 0 keeps flag", rv, 32'h2);
      wr(5'h10, 32'h2);
      rd(5'h10, rv);  chk("R5 write 1 clears", rv, 0);
      chk("R6 irq drops", {31'd0, irq}, 0);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = 5'h10; bus_wdata = 32'h2; eng_rx_end = 1;
      @(negedge clk);
      bus_sel = 0; bus_we = 0; eng_rx_end = 0;
      rd(5'h10, rv);  chk("R5 set beats clear", rv, 32'h2);
      wr(5'h10, 32'h1FFF);
      wr(5'h14, 32'h0);

      // R7 multi-byte message
      wr(5'h00, 32'h3);
      wr(5'h08, 32'hA1);
      chk("R7 byte loaded", {23'd0, eng_tx_valid, eng_tx_byte}, {23'd0, 1'b1, 8'hA1});
      pulse(0);
      chk("R7 byte taken", {31'd0, eng_tx_valid}, 0);
      rd(5'h10, rv);  chk("R7 byte request", rv, 32'h100);
      wr(5'h10, 32'h100);
      wr(5'h08, 32'hB2);
      wr(5'h00, 32'h7);
      pulse(0);
      rd(5'h10, rv);  chk("R7 no request after last", rv, 0);
      pulse(1);
      rd(5'h00, rv);  chk("R8 commands cleared on end", rv, 32'h1);
      rd(5'h10, rv);  chk("R8 tx end flag", rv, 32'h200);
      wr(5'h10, 32'h1FFF);

      // one-byte message: end before start
      wr(5'h00, 32'h5);
      wr(5'h00, 32'h7);
      wr(5'h08, 32'h44);
      chk("R3 both commands set", {30'd0, eng_som, eng_eom}, 2'b11);
      pulse(0);
      rd(5'h10, rv);  chk("R7 one-byte no request", rv, 0);
      pulse(1);
      wr(5'h10, 32'h1FFF);

      // R8 other outcomes
      for (int k = 2; k <= 4; k++) begin
         wr(5'h00, 32'h3);
         pulse(k);
         rd(5'h00, rv);  chk($sformatf("R8 cleared by event %0d", k), rv, 32'h1);
         rd(5'h10, rv);
         chk($sformatf("R8 flag for event %0d", k), rv,
             (k == 2) ? 32'h800 : (k == 3) ? 32'h1000 : 32'h80);
         wr(5'h10, 32'h1FFF);
      end

      // R9 underrun and ignored take
      wr(5'h00, 32'h3);
      pulse(0);
      rd(5'h10, rv);  chk("R9 underrun flag", rv, 32'h400);
      rd(5'h00, rv);  chk("R9 commands aborted", rv, 32'h1);
      wr(5'h10, 32'h1FFF);
      pulse(0);
      rd(5'h10, rv);  chk("R9 take without start ignored", rv, 0);

      // R10 receive
      rx_byte(8'h5A);
      rd(5'h10, rv);  chk("R10 byte flag", rv, 32'h1);
      rd(5'h0C, rv);  chk("R10 rx data", rv, 32'h5A);
      pulse(6);
      rd(5'h10, rv);  chk("R10 rx nack flag", rv, 32'h41);
      wr(5'h10, 32'h1FFF);

      // R11 overrun
      rx_byte(8'h11);
      rx_byte(8'h22);
      rd(5'h10, rv);  chk("R11 overrun flag", rv, 32'h5);
      rd(5'h0C, rv);  chk("R11 new byte discarded", rv, 32'h11);
      wr(5'h10, 32'h1FFF);
      rx_byte(8'h33);
      rd(5'h10, rv);  chk("R11 buffer emptied", rv, 32'h1);
      rd(5'h0C, rv);  chk("R11 next byte stored", rv, 32'h33);
      wr(5'h10, 32'h1FFF);

      // R3 disable
      wr(5'h00, 32'h3);
      wr(5'h00, 32'h0);
      rd(5'h00, rv);  chk("R3 disable clears commands", rv, 0);
      wr(5'h00, 32'h6);
      rd(5'h00, rv);  chk("R3 commands ignored while disabled", rv, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule